// File: doc/BRIEF.md
# Synchronizable Programmable Clock Divider

This block divides its input clock by an integer ratio from 1 to 8. It has two outputs. One is a clock-enable pulse that is high for one input cycle at the start of each divided period. The other is a registered divided clock with a near-50% duty cycle. A small control word, written through a one-cycle write strobe, sets the ratio and the synchronization behaviour.

An external SYNC line can return the divider to its starting phase. Several copies of the block that receive the same SYNC therefore divide in lock-step. Realignment can be switched off. When it is on, it runs in one of two modes: every rising SYNC edge realigns the divider, or only the first edge after a control write does. In the second mode, each control write re-arms the divider, and a status pin shows that the re-arm is still pending.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle strobe, and no input can be back-pressured.

Top module: `clkdiv_sync`

## Requirements
- R1: After reset the divide ratio is 1, realignment is disabled, `div_en` and `div_clk` are high and `oneshot_armed` is low.
- R2: A control write captures `cfg_wdata` at the clock edge where `cfg_we` is high. Bits [2:0] hold the ratio minus one (0 means divide by 1, 7 means divide by 8). Bit 3 enables realignment. Bit 4 selects one-shot mode when 1 and every-edge mode when 0.
- R3: With ratio N, `div_en` is high for exactly one cycle in every N cycles, in the cycle where the phase count is zero. For N = 1 it stays high.
- R4: `div_clk` is high during phase counts 0 to ceil(N/2)-1 of each period and low during the rest. For N = 1 it equals `div_en`.
- R5: A valid SYNC event is `sync_in` sampled low at one clock edge and high at the next. When realignment accepts it, the cycle after that edge has phase count zero. Holding `sync_in` high causes only that one realignment.
- R6: While realignment is disabled, SYNC edges leave the phase count running undisturbed.
- R7: In one-shot mode, the first valid SYNC after a control write realigns the divider. Later edges are ignored until the next control write.
- R8: `oneshot_armed` is high from the cycle after a write with bits 4 and 3 both set until that write's SYNC has been consumed. It is low otherwise.
- R9: A new ratio takes effect when the current period wraps, or at once on an accepted SYNC, whichever comes first. No period is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 5 | Control word: ratio-1, realign enable, one-shot select |
| sync_in | input | 1 | External alignment signal |
| div_en | output | 1 | One-cycle pulse at the start of each divided period |
| div_clk | output | 1 | Registered divided clock |
| oneshot_armed | output | 1 | One-shot realignment still pending |

## Verification
The bench builds the block with its default 3-bit ratio field, so only eight ratios exist. That makes it practical to sweep every ratio over several whole periods after a realignment and compare both outputs, cycle by cycle, against the phase computed as the elapsed count modulo N. The small field also keeps every period short, so each test can reach the cases that depend on phase in a few cycles: a ratio change part-way through a period, SYNC held high, SYNC while disabled, and a second SYNC in one-shot mode.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int RATIO_W = 3;
  localparam int CFG_W   = RATIO_W + 2;

  typedef struct packed {
    logic               oneshot;
    logic               sync_en;
    logic [RATIO_W-1:0] ratio_m1;
  } div_cfg_t;
endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             consume,
  output div_cfg_t         cfg,
  output logic             armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      armed <= 1'b0;
    end else begin
      if (we) cfg <= div_cfg_t'(wdata);
      // a write re-arms; it wins over a same-cycle consumption
      if (we)           armed <= 1'b1;
      else if (consume) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/clkdiv_sync_det.sv
module clkdiv_sync_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic rise
);
  logic prev_q;

  // resets high so a level already present at reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_in;
  end

  assign rise = sync_in & ~prev_q;
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         realign,
  input  logic [W-1:0] ratio_m1_next,
  output logic [W-1:0] act_m1,
  output logic         div_en,
  output logic         div_clk
);
  localparam int LW = W + 1;

  logic [W-1:0]  cnt_q, cnt_d, act_d;
  logic [LW-1:0] high_lim;
  logic          clk_d;

  always_comb begin
    if (realign || (cnt_q == act_m1)) begin
      cnt_d = '0;
      act_d = ratio_m1_next;
    end else begin
      cnt_d = cnt_q + 1'b1;
      act_d = act_m1;
    end
    high_lim = ({1'b0, act_d} + LW'(2)) >> 1;
    clk_d    = ({1'b0, cnt_d} < high_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_m1  <= '0;
      div_clk <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      act_m1  <= act_d;
      div_clk <= clk_d;
    end
  end

  assign div_en = (cnt_q == '0);
endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             sync_in,
  output logic             div_en,
  output logic             div_clk,
  output logic             oneshot_armed
);
  div_cfg_t           cfg_q;
  logic               arm_q;
  logic               sync_rise;
  logic               realign;
  logic [RATIO_W-1:0] act_m1;

  clkdiv_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .consume (realign & cfg_q.oneshot),
    .cfg     (cfg_q),
    .armed   (arm_q)
  );

  clkdiv_sync_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .rise    (sync_rise)
  );

  assign realign = sync_rise & cfg_q.sync_en & (~cfg_q.oneshot | arm_q);

  clkdiv_counter #(.W(RATIO_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .realign       (realign),
    .ratio_m1_next (cfg_q.ratio_m1),
    .act_m1        (act_m1),
    .div_en        (div_en),
    .div_clk       (div_clk)
  );

  assign oneshot_armed = arm_q & cfg_q.oneshot & cfg_q.sync_en;
endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk
  import clkdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sync_in,
  input logic               cfg_we,
  input logic               wr_oneshot,
  input logic               wr_sync_en,
  input logic               div_en,
  input logic               div_clk,
  input logic               oneshot_armed,
  input logic               sync_en,
  input logic               oneshot,
  input logic [RATIO_W-1:0] act_m1
);
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  // R5: an accepted rising SYNC puts phase zero in the next cycle
  p_sync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && sync_in && !$past(sync_in) && sync_en && (!oneshot || oneshot_armed))
      |=> div_en);

  // R6: with realignment off, a period longer than one never restarts early
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && act_m1 != '0 && !sync_en) |=> !div_en);

  // R4: phase zero always lies in the high part of the divided clock
  p_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |-> div_clk);

  // R8: the status follows the mode bits of each write
  p_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (oneshot_armed == ($past(wr_oneshot) && $past(wr_sync_en))));

  // R3: for a ratio of one the enable never drops
  p_div1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m1 == '0) |-> div_en);
endmodule

bind clkdiv_sync clkdiv_sync_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_in       (sync_in),
  .cfg_we        (cfg_we),
  .wr_oneshot    (cfg_wdata[4]),
  .wr_sync_en    (cfg_wdata[3]),
  .div_en        (div_en),
  .div_clk       (div_clk),
  .oneshot_armed (oneshot_armed),
  .sync_en       (cfg_q.sync_en),
  .oneshot       (cfg_q.oneshot),
  .act_m1        (act_m1)
);

// File: tb/test_clkdiv_sync.sv
module test_clkdiv_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       sync_in = 1'b0;
  logic       div_en, div_clk, oneshot_armed;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkdiv_sync i_clkdiv_sync (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sync_in(sync_in), .div_en(div_en), .div_clk(div_clk),
    .oneshot_armed(oneshot_armed)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // expected outputs at phase k of a period of n
  task automatic check_phase(string req, int n, int k);
    check({req, " div_en"},  int'(div_en),  int'((k % n) == 0));
    check({req, " div_clk"}, int'(div_clk), int'((k % n) < (n + 1) / 2));
  endtask

  // called at a negedge; write lands at the next posedge
  task automatic write_cfg(bit os, bit en, int n);
    cfg_we    = 1'b1;
    cfg_wdata = {os, en, 3'(n - 1)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_zero();
    int guard = 0;
    while (!div_en && guard < 20) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 div_en", int'(div_en), 1);
    check("R1 div_clk", int'(div_clk), 1);
    check("R1 armed", int'(oneshot_armed), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 div by 1 after reset", int'(div_en), 1);

    // R2 R3 R4 R5 R9: every ratio, every-edge mode, realigned by SYNC
    for (int n = 1; n <= 8; n++) begin
      write_cfg(1'b0, 1'b1, n);
      check("R8 armed low in every-edge mode", int'(oneshot_armed), 0);
      @(negedge clk);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      for (int k = 0; k < 3 * n; k++) begin
        check_phase("R3 R4 R5 R9 sweep", n, k);
        @(negedge clk);
      end
    end

    // R9: ratio change mid-period waits for the wrap
    write_cfg(1'b0, 1'b1, 8);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (k == 2) begin
        cfg_we = 1'b1;
        cfg_wdata = {2'b01, 3'd2};
      end else begin
        cfg_we = 1'b0;
      end
      if (k < 8) check_phase("R9 old period kept", 8, k);
      else       check_phase("R9 new period", 3, k - 8);
      @(negedge clk);
    end
    cfg_we = 1'b0;

    // R5: SYNC held high realigns once
    write_cfg(1'b0, 1'b1, 4);
    repeat (6) @(negedge clk);
    wait_zero();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      check_phase("R5 held high", 4, k);
      @(negedge clk);
    end
    sync_in = 1'b0;
    @(negedge clk);

    // R6: realignment disabled
    write_cfg(1'b0, 1'b0, 4);
    wait_zero();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    for (int k = 2; k < 10; k++) begin
      check_phase("R6 sync ignored", 4, k);
      @(negedge clk);
    end

    // R7 R8: one-shot mode
    write_cfg(1'b1, 1'b1, 4);
    check("R8 armed after write", int'(oneshot_armed), 1);
    wait_zero();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    check("R8 armed cleared by sync", int'(oneshot_armed), 0);
    for (int k = 0; k < 5; k++) begin
      check_phase("R7 first sync realigns", 4, k);
      @(negedge clk);
    end
    wait_zero();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    for (int k = 2; k < 8; k++) begin
      check_phase("R7 second sync ignored", 4, k);
      @(negedge clk);
    end
    write_cfg(1'b1, 1'b1, 4);
    check("R8 re-armed by write", int'(oneshot_armed), 1);
    wait_zero();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check_phase("R7 re-armed sync realigns", 4, k);
      @(negedge clk);
    end
    write_cfg(1'b1, 1'b0, 4);
    check("R8 low when disabled", int'(oneshot_armed), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule